// File: doc/BRIEF.md
# USB Idle-Line Speed and Event Monitor

This block watches a sampled full-speed or low-speed USB line pair while the bus is not carrying a packet. It sorts each sample of the two data lines into a line-state code and times every run of single-ended zero (both lines low). When such a run ends, the block decides whether it was a bus reset or a low-speed keep-alive, and it reports that with a one-cycle pulse. Runs are timed in samples of a 48 MHz clock. Full-speed traffic signals at 12 Mb/s and low-speed traffic at 1.5 Mb/s.

A two-bit mode input selects the speed. It can be fixed at full-speed, fixed at low-speed, or left automatic. In automatic mode the active speed follows the first non-zero line state that appears after a single-ended-zero run. If D+ is high, the bus is full-speed. If D- is high, the bus is low-speed. A bus reset always sets the active speed back to the configured one. The J and K meaning of the line-state code follows the active speed.

Internally a control state machine has two states. `ST_LINE` means the lines are in some non-zero state. `ST_SE0_RUN` means a single-ended-zero run is being timed. The machine makes three transitions:
- `LINE_TO_RUN` on the first zero sample.
- `RUN_HOLD` while zero samples continue.
- `RUN_END` on the first non-zero sample.

The `RUN_END` transition is where the run length is judged and the speed is updated.

Top module: `usb_line_monitor`

## Requirements
- R1: `line_state` is combinational from `dp`, `dm` and the active speed. The codes are: 0 when both lines are low, 3 when both are high, 1 (J) for the idle polarity of the active speed, and 2 (K) for the opposite polarity. The idle polarity is `dp`=1 at full speed and `dm`=1 at low speed.
- R2: A zero run of more than 120 samples gives `bus_reset_pulse` high for exactly one cycle, in the cycle after the first non-zero sample.
- R3: A zero run of 59 to 120 samples gives `keepalive_pulse` for one cycle, at the same timing as R2, but only when the active speed before the run ended was low-speed. A full-speed bus never gets a keep-alive pulse.
- R4: A zero run of exactly one sample produces no pulse and no change of speed.
- R5: In automatic mode (`mode_sel` 00, with 11 treated the same way), a run of two or more samples sets the active speed when it ends. If the first non-zero sample has `dp`=1, `dm`=0, the speed becomes full (`speed_ls`=0). If it has `dp`=0, `dm`=1, the speed becomes low (`speed_ls`=1).
- R6: On a bus reset the active speed is set to the configured speed: low for `mode_sel`=10, and full otherwise. In automatic mode, R5 detection then applies to the same sample.
- R7: While `rst` is high, and in the first cycle after it, the active speed equals the configured speed and both pulses are low.
- R8: A run that ends with both lines high leaves the speed unchanged, except for the reversion described in R6.
- R9: The two pulses are never high together, and neither stays high for two cycles in a row.
- R10: In fixed modes (`mode_sel` 01 or 10), the idle polarity never changes the active speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz sample clock |
| rst | input | 1 | Synchronous active-high reset |
| dp | input | 1 | Synchronized D+ sample |
| dm | input | 1 | Synchronized D- sample |
| mode_sel | input | 2 | 00 automatic, 01 full-speed, 10 low-speed, 11 automatic |
| speed_ls | output | 1 | Active speed, 1 = low-speed |
| line_state | output | 2 | 0 zero, 1 J, 2 K, 3 both high |
| bus_reset_pulse | output | 1 | One-cycle bus reset event |
| keepalive_pulse | output | 1 | One-cycle low-speed keep-alive event |

## Verification
The bench sweeps run lengths at each threshold edge (1, 2, 58, 59, 120, 121, 122), under every mode and for each of the three ending polarities. Each case is compared against a small arithmetic model of speed and events.

Several kinds of design error show up in this sweep:
- An off-by-one in the counter, or `>=` in place of `>`, moves a pulse to 58 or 120 samples, or drops it at 59 or 121.
- A design that does not suppress glitches changes speed after a single zero sample.
- A design that skips reversion keeps low-speed after a reset in full mode.
- A design that detects speed in fixed modes flips `speed_ls`.
- A design that gates keep-alive on the updated speed, rather than the prior speed, misses or invents pulses when the speed changes at the end of a run.

// File: rtl/usb_lm_pkg.sv
package usb_lm_pkg;

    typedef enum logic [1:0] {
        PAIR_SE0 = 2'd0,
        PAIR_DP  = 2'd1,
        PAIR_DM  = 2'd2,
        PAIR_SE1 = 2'd3
    } pair_t;

    typedef enum logic [1:0] {
        LC_SE0 = 2'd0,
        LC_J   = 2'd1,
        LC_K   = 2'd2,
        LC_SE1 = 2'd3
    } line_code_t;

    typedef enum logic {
        ST_LINE,
        ST_SE0_RUN
    } mon_state_t;

    localparam logic [1:0] MODE_AUTO = 2'b00;
    localparam logic [1:0] MODE_FULL = 2'b01;
    localparam logic [1:0] MODE_LOW  = 2'b10;

endpackage

// File: rtl/usb_lm_classify.sv
module usb_lm_classify
    import usb_lm_pkg::*;
(
    input  logic       dp,
    input  logic       dm,
    input  logic       speed_ls,
    output pair_t      pair,
    output line_code_t code
);

    always_comb begin
        unique case ({dp, dm})
            2'b00:   pair = PAIR_SE0;
            2'b10:   pair = PAIR_DP;
            2'b01:   pair = PAIR_DM;
            default: pair = PAIR_SE1;
        endcase
    end

    // J is the idle polarity of the active speed
    always_comb begin
        unique case (pair)
            PAIR_SE0: code = LC_SE0;
            PAIR_SE1: code = LC_SE1;
            PAIR_DP:  code = speed_ls ? LC_K : LC_J;
            PAIR_DM:  code = speed_ls ? LC_J : LC_K;
            default:  code = LC_SE0;
        endcase
    end

endmodule

// File: rtl/usb_lm_se0_timer.sv
module usb_lm_se0_timer #(
    parameter int RESET_CYCLES = 120,
    parameter int KA_CYCLES    = 58
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic hold,
    output logic over_reset,
    output logic over_ka,
    output logic is_glitch
);

    localparam int SAT_VAL = RESET_CYCLES + 1;
    localparam int CNT_W   = $clog2(SAT_VAL + 1);
    localparam logic [CNT_W-1:0] SAT_C   = CNT_W'(SAT_VAL);
    localparam logic [CNT_W-1:0] RESET_C = CNT_W'(RESET_CYCLES);
    localparam logic [CNT_W-1:0] KA_C    = CNT_W'(KA_CYCLES);

    logic [CNT_W-1:0] run_len;

    // counts zero samples in the current run, saturating past the reset limit
    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (start) begin
            run_len <= CNT_W'(1);
        end else if (hold && run_len != SAT_C) begin
            run_len <= run_len + CNT_W'(1);
        end
    end

    assign over_reset = run_len > RESET_C;
    assign over_ka    = run_len > KA_C;
    assign is_glitch  = run_len <= CNT_W'(1);

endmodule

// File: rtl/usb_lm_ctrl.sv
module usb_lm_ctrl
    import usb_lm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pair_t      pair,
    input  logic [1:0] mode_sel,
    input  logic       over_reset,
    input  logic       over_ka,
    input  logic       is_glitch,
    output logic       start,
    output logic       hold,
    output logic       speed_ls,
    output logic       bus_reset_pulse,
    output logic       keepalive_pulse
);

    mon_state_t state, state_nxt;
    logic       cfg_ls;
    logic       auto_mode;
    logic       run_end;
    logic       speed_nxt;
    logic       rst_evt;
    logic       ka_evt;

    assign cfg_ls    = (mode_sel == MODE_LOW);
    assign auto_mode = (mode_sel != MODE_FULL) && (mode_sel != MODE_LOW);

    // LINE_TO_RUN / RUN_HOLD / RUN_END transitions
    always_comb begin
        start     = 1'b0;
        hold      = 1'b0;
        run_end   = 1'b0;
        state_nxt = state;
        unique case (state)
            ST_LINE: begin
                if (pair == PAIR_SE0) begin
                    start     = 1'b1;
                    state_nxt = ST_SE0_RUN;
                end
            end
            ST_SE0_RUN: begin
                if (pair == PAIR_SE0) begin
                    hold = 1'b1;
                end else begin
                    run_end   = 1'b1;
                    state_nxt = ST_LINE;
                end
            end
            default: state_nxt = ST_LINE;
        endcase
    end

    // judge the finished run and derive the next speed
    always_comb begin
        rst_evt   = 1'b0;
        ka_evt    = 1'b0;
        speed_nxt = speed_ls;
        if (run_end && !is_glitch) begin
            if (over_reset) begin
                rst_evt   = 1'b1;
                speed_nxt = cfg_ls;
            end else if (over_ka && speed_ls) begin
                ka_evt = 1'b1;
            end
            if (auto_mode && pair == PAIR_DP) begin
                speed_nxt = 1'b0;
            end else if (auto_mode && pair == PAIR_DM) begin
                speed_nxt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LINE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            speed_ls        <= cfg_ls;
            bus_reset_pulse <= 1'b0;
            keepalive_pulse <= 1'b0;
        end else begin
            speed_ls        <= speed_nxt;
            bus_reset_pulse <= rst_evt;
            keepalive_pulse <= ka_evt;
        end
    end

endmodule

// File: rtl/usb_line_monitor.sv
module usb_line_monitor
    import usb_lm_pkg::*;
#(
    parameter int RESET_CYCLES = 120,
    parameter int KA_CYCLES    = 58
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dp,
    input  logic       dm,
    input  logic [1:0] mode_sel,
    output logic       speed_ls,
    output logic [1:0] line_state,
    output logic       bus_reset_pulse,
    output logic       keepalive_pulse
);

    pair_t      pair;
    line_code_t code;
    logic       start;
    logic       hold;
    logic       over_reset;
    logic       over_ka;
    logic       is_glitch;

    usb_lm_classify i_classify (
        .dp       (dp),
        .dm       (dm),
        .speed_ls (speed_ls),
        .pair     (pair),
        .code     (code)
    );

    usb_lm_se0_timer #(
        .RESET_CYCLES (RESET_CYCLES),
        .KA_CYCLES    (KA_CYCLES)
    ) i_timer (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .hold       (hold),
        .over_reset (over_reset),
        .over_ka    (over_ka),
        .is_glitch  (is_glitch)
    );

    usb_lm_ctrl i_ctrl (
        .clk             (clk),
        .rst             (rst),
        .pair            (pair),
        .mode_sel        (mode_sel),
        .over_reset      (over_reset),
        .over_ka         (over_ka),
        .is_glitch       (is_glitch),
        .start           (start),
        .hold            (hold),
        .speed_ls        (speed_ls),
        .bus_reset_pulse (bus_reset_pulse),
        .keepalive_pulse (keepalive_pulse)
    );

    assign line_state = code;

endmodule

// File: rtl/usb_line_monitor_chk.sv
module usb_line_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic       dp,
    input logic       dm,
    input logic [1:0] mode_sel,
    input logic       speed_ls,
    input logic [1:0] line_state,
    input logic       bus_reset_pulse,
    input logic       keepalive_pulse
);

    logic [7:0] zero_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_run <= '0;
        end else if (!dp && !dm) begin
            if (zero_run != 8'hFF) zero_run <= zero_run + 8'd1;
        end else begin
            zero_run <= '0;
        end
    end

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_reset_pulse && keepalive_pulse)); // R9

    AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (rst)
        bus_reset_pulse |=> !bus_reset_pulse); // R2

    AST_KA_SINGLE: assert property (@(posedge clk) disable iff (rst)
        keepalive_pulse |=> !keepalive_pulse); // R3

    AST_KA_LOWSPEED: assert property (@(posedge clk) disable iff (rst)
        keepalive_pulse |-> $past(speed_ls)); // R3

    AST_REVERT_FULL: assert property (@(posedge clk) disable iff (rst)
        (bus_reset_pulse && $past(mode_sel) == 2'b01) |-> !speed_ls); // R6

    AST_REVERT_LOW: assert property (@(posedge clk) disable iff (rst)
        (bus_reset_pulse && $past(mode_sel) == 2'b10) |-> speed_ls); // R6

    AST_GLITCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (zero_run == 8'd1 && (dp || dm)) |=>
        (!bus_reset_pulse && !keepalive_pulse && $stable(speed_ls))); // R4

    AST_ZERO_CODE: assert property (@(posedge clk) disable iff (rst)
        (line_state == 2'd0) |-> (!dp && !dm)); // R1

endmodule

bind usb_line_monitor usb_line_monitor_chk i_chk (
    .clk             (clk),
    .rst             (rst),
    .dp              (dp),
    .dm              (dm),
    .mode_sel        (mode_sel),
    .speed_ls        (speed_ls),
    .line_state      (line_state),
    .bus_reset_pulse (bus_reset_pulse),
    .keepalive_pulse (keepalive_pulse)
);

// File: tb/test_usb_line_monitor.sv
`timescale 1ns/1ps
module test_usb_line_monitor;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dp = 1'b1;
    logic       dm = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       speed_ls;
    logic [1:0] line_state;
    logic       bus_reset_pulse;
    logic       keepalive_pulse;

    int checks = 0;
    int failures = 0;
    bit model_ls;
    bit done = 1'b0;

    always #2 clk = ~clk;

    usb_line_monitor i_usb_line_monitor (
        .clk             (clk),
        .rst             (rst),
        .dp              (dp),
        .dm              (dm),
        .mode_sel        (mode_sel),
        .speed_ls        (speed_ls),
        .line_state      (line_state),
        .bus_reset_pulse (bus_reset_pulse),
        .keepalive_pulse (keepalive_pulse)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit cfg_of(logic [1:0] m);
        return (m == 2'b10);
    endfunction

    function automatic bit is_auto(logic [1:0] m);
        return (m == 2'b00) || (m == 2'b11);
    endfunction

    // R1: sweep all four pairs against the current speed
    task automatic line_sweep();
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            dp = p[1];
            dm = p[0];
            #0.5;
            if (dp && dm) check("R1 code", line_state, 3);
            else if (!dp && !dm) check("R1 code", line_state, 0);
            else check("R1 code", line_state, (dp ^ model_ls) ? 1 : 2);
        end
    endtask

    task automatic run_se0(int n, bit edp, bit edm);
        bit exp_rst;
        bit exp_ka;
        bit new_ls;
        @(negedge clk);
        dp = 1'b0;
        dm = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (bus_reset_pulse || keepalive_pulse) check("R9 quiet in run", 1, 0);
        end
        dp = edp;
        dm = edm;
        exp_rst = (n > 120);
        exp_ka  = !exp_rst && (n > 58) && model_ls;
        new_ls  = model_ls;
        if (n >= 2) begin
            if (exp_rst) new_ls = cfg_of(mode_sel);
            if (is_auto(mode_sel) && (edp ^ edm)) new_ls = edm;
        end
        @(negedge clk);
        if (n == 1) begin
            check("R4 glitch reset", bus_reset_pulse, 0);
            check("R4 glitch keepalive", keepalive_pulse, 0);
            check("R4 glitch speed", speed_ls, model_ls);
        end else begin
            check("R2 reset pulse", bus_reset_pulse, exp_rst);
            check("R3 keepalive pulse", keepalive_pulse, exp_ka);
            if (exp_rst && !is_auto(mode_sel)) check("R6 revert", speed_ls, new_ls);
            else if (!is_auto(mode_sel)) check("R10 fixed speed", speed_ls, new_ls);
            else if (edp && edm) check("R8 SE1 end", speed_ls, new_ls);
            else check("R5 auto detect", speed_ls, new_ls);
        end
        model_ls = new_ls;
        @(negedge clk);
        check("R9 reset one cycle", bus_reset_pulse, 0);
        check("R9 keepalive one cycle", keepalive_pulse, 0);
    endtask

    initial begin
        int lens[7] = '{1, 2, 58, 59, 120, 121, 122};
        for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            mode_sel = 2'(m);
            rst = 1'b1;
            dp = 1'b1;
            dm = 1'b0;
            repeat (2) @(negedge clk);
            check("R7 speed in reset", speed_ls, cfg_of(mode_sel));
            rst = 1'b0;
            @(negedge clk);
            check("R7 speed after reset", speed_ls, cfg_of(mode_sel));
            check("R7 reset pulse low", bus_reset_pulse, 0);
            check("R7 keepalive low", keepalive_pulse, 0);
            model_ls = cfg_of(mode_sel);
            line_sweep();
            for (int k = 0; k < 7; k++) begin
                run_se0(lens[k], 1'b0, 1'b1);
                line_sweep();
                run_se0(lens[k], 1'b1, 1'b1);
                run_se0(lens[k], 1'b1, 1'b0);
                line_sweep();
                run_se0(lens[k], 1'b0, 1'b1);
                run_se0(lens[k], 1'b1, 1'b1);
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule